// File: doc/BRIEF.md
# Lock-Qualified Reset Pulse Stretcher

This block drives an active-low, open-drain processor reset line that also tells the system whether the PLL is locked. It runs in the PLL output clock domain. While the PLL is out of lock the line is pulled low. Once lock is present and nobody is requesting a reset, the line is let go, and an external pull-up brings it high. The block never drives the line high. Its output is therefore a single drive-enable bit: 1 pulls the line low, and 0 leaves it floating.

A reset request arrives on an asynchronous active-low input. A flop with an asynchronous set catches it, so a pulse shorter than one clock period is not lost. A two-stage synchronizer then carries it into the clock domain. While the request is low, the line stays low. When the request ends, a counter measures a fixed number of output clock cycles (1024 by default) before the line is released. A new request, or a loss of lock, clears the counter and starts the count again from zero. The block has no effect on its clock, so the clocks keep running while the processor is held in reset.

Top module: `lock_reset_stretcher`

## Requirements
- R1: While `rst_n` is low, `rst_out_oe` is 1. Encoding: 1 means the line is driven low, and 0 means the line is released to high impedance.
- R2: Whenever `pll_locked` is 0, `rst_out_oe` is 1 at once, in the same cycle, and the cycle counter is cleared.
- R3: After `rst_n` rises, with lock present and no request, `rst_out_oe` falls to 0 on exactly the 1024th rising clock edge.
- R4: A low pulse on `req_n` that starts and ends between two clock edges is still recognised, and `rst_out_oe` is 1 after the third rising edge that follows the pulse's start.
- R5: `rst_out_oe` falls to 0 on exactly the 1027th rising edge after `req_n` returns high. This is two synchronizer stages, one clearing cycle, and then 1024 counted cycles.
- R6: While `req_n` is held low, `rst_out_oe` stays 1 however long the request lasts.
- R7: A new request that arrives while a count is running clears the counter. The full count is then measured again from the end of the new request.
- R8: When lock returns, with no request present, `rst_out_oe` falls to 0 on exactly the 1024th rising edge after `pll_locked` rises.
- R9: The counter never goes above the count length. The release always happens on the cycle at which the counter reaches the count length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PLL output clock |
| rst_n | input | 1 | Active-low reset for the clock domain, asynchronous assert |
| req_n | input | 1 | Asynchronous active-low reset request |
| pll_locked | input | 1 | PLL lock flag, synchronous to `clk` |
| rst_out_oe | output | 1 | Open-drain enable: 1 pulls the reset line low, 0 releases it |

## Verification
Each result has a known due time. The line asserts on the third rising edge after a request begins. Release follows 1027 edges after a request ends, and 1024 edges after lock or the reset input returns. Loss of lock shows on the output within the same cycle. The bench drives and samples only at falling edges, so each step of its wait counts exactly one rising edge. It checks the level both one edge before and at the due edge, which catches a release that comes one cycle early or one cycle late. The short request pulse is placed wholly between two rising edges, so only the asynchronous capture can see it.

// File: rtl/lock_reset_stretcher.sv
module lock_reset_stretcher #(
  parameter int COUNT_LEN   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_n,
  input  logic pll_locked,
  output logic rst_out_oe
);

  localparam int CW = $clog2(COUNT_LEN) + 1;
  localparam logic [CW-1:0] LAST = CW'(COUNT_LEN - 1);
  localparam logic [CW-1:0] FULL = CW'(COUNT_LEN);

  logic                   cap;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   req_sync;
  logic [CW-1:0]          cnt;
  logic                   hold;

  always_ff @(posedge clk or negedge req_n)
    if (!req_n) cap <= 1'b1;
    else        cap <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cap};

  assign req_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (!pll_locked || req_sync) begin
      cnt  <= '0;
      hold <= 1'b1;
    end else if (hold) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) hold <= 1'b0;
    end

  assign rst_out_oe = hold | ~pll_locked;

  AST_CAP_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !req_n |-> cap); // R4
  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    req_sync |=> (cnt == '0 && hold)); // R7
  AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_locked |=> (cnt == '0 && rst_out_oe)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL); // R9
  AST_RELEASE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold) |-> cnt == FULL); // R9
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && cnt < LAST) |=> hold); // R6

endmodule

// File: tb/lock_reset_stretcher_test.sv
module lock_reset_stretcher_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_n = 1'b1;
  logic pll_locked = 1'b1;
  logic rst_out_oe;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lock_reset_stretcher uut (
    .clk(clk), .rst_n(rst_n), .req_n(req_n),
    .pll_locked(pll_locked), .rst_out_oe(rst_out_oe)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_oe(input logic exp, input string req);
    checks++;
    if (rst_out_oe !== exp) begin
      errors++;
      $display("FAIL %s rst_out_oe=%b expected=%b at %0t", req, rst_out_oe, exp, $time);
    end
  endtask

  task automatic short_pulse;
    @(negedge clk);
    #2 req_n = 1'b0;
    #6 req_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    step(3);
    expect_oe(1'b1, "R1 in reset");
    rst_n = 1'b1;
    step(1023);
    expect_oe(1'b1, "R3 edge 1023");
    step(1);
    expect_oe(1'b0, "R3 edge 1024");
  endtask

  task automatic t_short;
    short_pulse();
    step(2);
    expect_oe(1'b1, "R4 short pulse seen");
    step(1023);
    expect_oe(1'b1, "R5 edge 1026");
    step(1);
    expect_oe(1'b0, "R5 edge 1027");
  endtask

  task automatic t_held;
    step(1);
    req_n = 1'b0;
    step(2);
    expect_oe(1'b0, "R4 edge 2 still released");
    step(1);
    expect_oe(1'b1, "R4 edge 3 asserted");
    step(1500);
    expect_oe(1'b1, "R6 held request");
    step(600);
    expect_oe(1'b1, "R6 long held request");
    req_n = 1'b1;
    step(1026);
    expect_oe(1'b1, "R5 held edge 1026");
    step(1);
    expect_oe(1'b0, "R5 held edge 1027");
  endtask

  task automatic t_retrigger;
    short_pulse();
    step(600);
    expect_oe(1'b1, "R7 mid count");
    short_pulse();
    step(1025);
    expect_oe(1'b1, "R7 restarted edge 1026");
    step(1);
    expect_oe(1'b0, "R7 restarted edge 1027");
  endtask

  task automatic t_lock;
    step(1);
    pll_locked = 1'b0;
    #1 expect_oe(1'b1, "R2 immediate on lock loss");
    step(5);
    expect_oe(1'b1, "R2 unlocked");
    pll_locked = 1'b1;
    step(1023);
    expect_oe(1'b1, "R8 edge 1023");
    step(1);
    expect_oe(1'b0, "R8 edge 1024");
    short_pulse();
    step(400);
    pll_locked = 1'b0;
    step(3);
    pll_locked = 1'b1;
    step(1023);
    expect_oe(1'b1, "R2 count cleared by lock loss");
    step(1);
    expect_oe(1'b0, "R8 release after relock");
  endtask

  initial begin
    t_reset();
    t_short();
    t_held();
    t_retrigger();
    t_lock();
    step(5);
    expect_oe(1'b0, "R9 stays released");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule